// File: doc/BRIEF.md
# Chained Timer Strobe Generator

This block turns a fast system clock, nominally 50 MHz from a crystal oscillator, into the slow timing signals a countdown timer needs. It does not use one wide counter. It chains several small modulo-N prescalers, and each stage advances only in the cycle in which the stage before it reaches its terminal count. Every flop runs on the one system clock, so no stage output is ever used as a clock.

The chain works in this order:

1. A first prescaler divides by 125, giving 400 kHz.
2. A second prescaler divides by 80, giving 5 kHz.
3. A third prescaler divides by 125, giving 40 Hz.
4. A toggle flop turns those 40 Hz terminal pulses into a 20 Hz square wave with 50 % duty, for the setup buttons.
5. A one-cycle setup strobe marks each falling edge of that square wave.
6. A final divide-by-20 stage counts the setup strobes and emits the one-cycle once-per-second count enable.

A separate tone prescaler also runs from the first stage's enable. Its own toggle flop produces an audible square wave. With the default tone divider of 133, the tone is about 1.5 kHz.

Setting `FAST_SIM` gives the first stage a smaller terminal count (default: divide by 10). The counter keeps the width the full-speed divisor needs. Every downstream period shrinks by the same ratio, so the behaviour can be checked in few cycles.

Top module: `tick_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every stage counter and toggle flop is cleared. From the cycle after that edge, all four outputs are 0. After `rst` falls, the timing restarts from state zero.
- R2: The first stage divides by `D1_SLOW` when `FAST_SIM`=0 and by `D1_FAST` when `FAST_SIM`=1. This sets every later period in proportion: the second period is P1*D2*D3*2*D4, where P1 is the first-stage divisor.
- R3: `sec_tick` is high for exactly one cycle per period P1*D2*D3*2*D4. Counting states from 0 after reset release, it is first high in state P1*D2*D3*2*D4-1.
- R4: `setup_sq` is a square wave of period 2*P1*D2*D3 with 50 % duty. It is 0 for the first P1*D2*D3 states after reset release and then 1 for the next P1*D2*D3 states.
- R5: `setup_tick` is a one-cycle pulse in the last state in which `setup_sq` is 1. In the following state, `setup_sq` is 0.
- R6: `sec_tick` is high only together with `setup_tick`, once every D4 setup strobes.
- R7: `tone_sq` is a square wave that starts at 0 and changes level every P1*TONE_DIV states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 50 MHz |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | output | 1 | One-cycle enable, once per second |
| setup_tick | output | 1 | One-cycle setup-rate strobe (20 Hz) |
| setup_sq | output | 1 | Setup-rate square wave (20 Hz, 50 % duty) |
| tone_sq | output | 1 | Audible square tone for the alarm |

## Verification
The condition that is hardest to reach from the ports is the wrap of the last stage, where every counter in the chain sits at its terminal value in the same cycle. At full rate that takes fifty million cycles. The bench therefore builds one instance with shortened divisors and the first stage in its fast mode, so every stage wraps many times within a few thousand cycles. A second instance keeps the full 125 first stage, and a run long enough to reach its first once-per-second tick shows that the fast setting changes only the first-stage period. A reset applied in the middle of a period checks that the chain restarts from zero and does not resume its old phase.

// File: rtl/tick_chain.sv
module tick_chain #(
  parameter int D1_SLOW  = 125,
  parameter int D1_FAST  = 10,
  parameter bit FAST_SIM = 1'b0,
  parameter int D2       = 80,
  parameter int D3       = 125,
  parameter int D4       = 20,
  parameter int TONE_DIV = 133
) (
  input  logic clk,
  input  logic rst,
  output logic sec_tick,
  output logic setup_tick,
  output logic setup_sq,
  output logic tone_sq
);

  localparam int W1 = (D1_SLOW > 1) ? $clog2(D1_SLOW) : 1;
  localparam int W2 = (D2 > 1) ? $clog2(D2) : 1;
  localparam int W3 = (D3 > 1) ? $clog2(D3) : 1;
  localparam int W4 = (D4 > 1) ? $clog2(D4) : 1;
  localparam int WT = (TONE_DIV > 1) ? $clog2(TONE_DIV) : 1;
  localparam int D1 = FAST_SIM ? D1_FAST : D1_SLOW;
  localparam logic [W1-1:0] L1 = W1'(D1 - 1);
  localparam logic [W2-1:0] L2 = W2'(D2 - 1);
  localparam logic [W3-1:0] L3 = W3'(D3 - 1);
  localparam logic [W4-1:0] L4 = W4'(D4 - 1);
  localparam logic [WT-1:0] LT = WT'(TONE_DIV - 1);

  logic [W1-1:0] c1;
  logic [W2-1:0] c2;
  logic [W3-1:0] c3;
  logic [W4-1:0] c4;
  logic [WT-1:0] ct;
  logic sq20, sqt;

  wire e1 = (c1 == L1);
  wire e2 = e1 && (c2 == L2);
  wire e3 = e2 && (c3 == L3);
  wire e20 = e3 && sq20;
  wire et = e1 && (ct == LT);

  always_ff @(posedge clk) begin
    if (rst) c1 <= '0;
    else     c1 <= e1 ? '0 : c1 + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     c2 <= '0;
    else if (e1) c2 <= (c2 == L2) ? '0 : c2 + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     c3 <= '0;
    else if (e2) c3 <= (c3 == L3) ? '0 : c3 + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     sq20 <= 1'b0;
    else if (e3) sq20 <= ~sq20;
  end

  always_ff @(posedge clk) begin
    if (rst)      c4 <= '0;
    else if (e20) c4 <= (c4 == L4) ? '0 : c4 + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     ct <= '0;
    else if (e1) ct <= (ct == LT) ? '0 : ct + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     sqt <= 1'b0;
    else if (et) sqt <= ~sqt;
  end

  assign setup_sq   = sq20;
  assign setup_tick = e20;
  assign sec_tick   = e20 && (c4 == L4);
  assign tone_sq    = sqt;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!sec_tick && !setup_tick && !setup_sq && !tone_sq));

  assert_first_stage_range_R2: assert property (@(posedge clk) disable iff (rst)
    c1 <= L1);

  assert_sec_single_R3: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);

  assert_setup_fall_R5: assert property (@(posedge clk) disable iff (rst)
    setup_tick |=> $fell(setup_sq));

  assert_fall_marked_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(setup_sq) |-> $past(setup_tick));

  assert_sec_on_setup_R6: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> setup_tick);

  assert_tone_step_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(tone_sq) || $fell(tone_sq)) |-> $past(e1));

endmodule

// File: tb/tick_chain_test.sv
module tick_chain_test;
  localparam int F1 = 10, S1 = 125, D2 = 4, D3 = 5, D4 = 3, TN = 3;
  localparam int P3F  = F1 * D2 * D3;
  localparam int SECF = 2 * P3F * D4;
  localparam int SECS = S1 * D2 * D3 * 2 * D4;

  logic clk = 1'b0, rst = 1'b1;
  logic sec_f, stb_f, sq_f, tone_f;
  logic sec_s, stb_s, sq_s, tone_s;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tick_chain #(.D1_SLOW(S1), .D1_FAST(F1), .FAST_SIM(1'b1), .D2(D2), .D3(D3),
               .D4(D4), .TONE_DIV(TN)) uut (
    .clk(clk), .rst(rst), .sec_tick(sec_f), .setup_tick(stb_f),
    .setup_sq(sq_f), .tone_sq(tone_f));

  tick_chain #(.D1_SLOW(S1), .D1_FAST(F1), .FAST_SIM(1'b0), .D2(D2), .D3(D3),
               .D4(D4), .TONE_DIV(TN)) uut_full (
    .clk(clk), .rst(rst), .sec_tick(sec_s), .setup_tick(stb_s),
    .setup_sq(sq_s), .tone_sq(tone_s));

  task automatic chk(input logic got, input logic exp, input string req, input int k);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s state=%0d got=%0b exp=%0b", req, k, got, exp);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string req);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic hold_reset(input int n);
    @(negedge clk) rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk(sec_f, 1'b0, "R1 sec_tick in reset", i);
      chk(stb_f, 1'b0, "R1 setup_tick in reset", i);
      chk(sq_f, 1'b0, "R1 setup_sq in reset", i);
      chk(tone_f, 1'b0, "R1 tone_sq in reset", i);
      chk(sq_s, 1'b0, "R1 full setup_sq in reset", i);
    end
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic run_span(input int n, output int nsf, output int nss, output int nstb);
    nsf = 0; nss = 0; nstb = 0;
    for (int k = 0; k < n; k++) begin
      #1;
      chk(sec_f, (k % SECF) == SECF - 1, "R3 sec_tick", k);
      chk(sq_f, ((k / P3F) % 2) == 1, "R4 setup_sq", k);
      chk(stb_f, (k % (2 * P3F)) == 2 * P3F - 1, "R5 setup_tick", k);
      chk(tone_f, ((k / (F1 * TN)) % 2) == 1, "R7 tone_sq", k);
      chk(sec_s, (k % SECS) == SECS - 1, "R2 full-rate sec_tick", k);
      if (sec_f && !stb_f) chk(1'b0, 1'b1, "R6 sec without setup strobe", k);
      if (sec_f) nsf++;
      if (sec_s) nss++;
      if (stb_f) nstb++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state;
    hold_reset(3);
  endtask

  task automatic t_fast_seconds;
    int nsf, nss, nstb;
    hold_reset(2);
    run_span(3 * SECF, nsf, nss, nstb);
    chk_int(nsf, 3, "R3 seconds in 3 periods");
    chk_int(nstb, 3 * D4, "R6 setup strobes in 3 seconds");
  endtask

  task automatic t_mid_reset;
    int nsf, nss, nstb;
    hold_reset(1);
    run_span(523, nsf, nss, nstb);
    hold_reset(2);
    run_span(SECF + 10, nsf, nss, nstb);
    chk_int(nsf, 1, "R1 restart gives one second");
  endtask

  task automatic t_full_rate;
    int nsf, nss, nstb;
    hold_reset(1);
    run_span(SECS + 50, nsf, nss, nstb);
    chk_int(nss, 1, "R2 full-rate seconds");
    chk_int(nsf, (SECS + 50) / SECF, "R2 fast-rate seconds");
  endtask

  initial begin
    #(4 * 190000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_fast_seconds();
    t_mid_reset();
    t_full_rate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule